// File: doc/BRIEF.md
# Processor I/O Port with Memory Bank Decode

This block is a small 8-bit bidirectional port built into a processor. It answers at two CPU addresses. Address $0000 holds a direction register, and address $0001 holds a data register. Each pin is driven from the data register when its direction bit is 1. It is sensed through a two-flop synchroniser when its direction bit is 0.

The low bits of the port also set the memory map. Bit 0 and bit 1 together control the language ROM in region $A000–$BFFF. Bit 1 alone controls the system ROM in region $E000–$FFFF. Bit 2 picks what appears at $D000: I/O registers when it is 1, character ROM when it is 0. Bit 3 is the tape data output, and bit 4 senses the tape switch. Bit 5 drives the tape motor. A bank bit whose pin is set as an input reads as a pulled-up 1. After reset the port gives the normal map, with both ROMs and I/O visible.

Top module: `pport_top`

## Requirements
- R1: While reset is held, and in the cycle after it, the direction register is $2F and the data register is $37. Therefore `pin_oe` is $2F and `pin_out` is $37.
- R2: A write strobe at address $0000 loads `cpu_wdata` into the direction register at the clock edge. `pin_oe` shows the new value from then on, and a read at $0000 returns it.
- R3: A write strobe at address $0001 loads the data register at the clock edge, and `pin_out` shows the new value.
- R4: A read at $0001 returns, for each bit, the data register where the direction bit is 1. Where the direction bit is 0, it returns the `pin_in` level as sampled two clock edges earlier.
- R5: A write to any address other than $0000 and $0001 changes neither register. A read of any other address returns $00.
- R6: A bank bit (0, 1 or 2) whose direction bit is 0 is treated as 1, whatever the data register holds.
- R7: `lang_rom_en` (region $A000–$BFFF) is 1 only when effective bits 0 and 1 are both 1.
- R8: `sys_rom_en` (region $E000–$FFFF) equals effective bit 1.
- R9: `io_visible` equals effective bit 2. A value of 1 maps I/O at $D000, and 0 maps character ROM there.
- R10: `motor_on` is 1 only when direction bit 5 and data bit 5 are both 1.
- R11: With direction $2F, writing $37 gives ROMs and I/O all visible. Writing $34 gives `lang_rom_en`=0, `sys_rom_en`=0 and `io_visible`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the current address |
| pin_in | input | 8 | Pin levels sensed from outside |
| pin_out | output | 8 | Values driven onto the pins |
| pin_oe | output | 8 | Per-pin output enable |
| lang_rom_en | output | 1 | Language ROM mapped at $A000–$BFFF |
| sys_rom_en | output | 1 | System ROM mapped at $E000–$FFFF |
| io_visible | output | 1 | 1: I/O at $D000; 0: character ROM |
| motor_on | output | 1 | Tape motor drive |

## Verification
The assertions take reset as synchronous. They also take `cpu_we`, `cpu_addr` and `cpu_wdata` as stable around each rising clock edge. The synchroniser check takes `pin_in` to be sampled cleanly at the clock edge, so it compares the synchronised value with the pin level from two edges before. The bench changes every input one time unit after a rising edge and holds it for the full cycle. It also waits at least two edges after any pin change before it expects to see that change on a read.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int unsigned PORT_W    = 8;
    localparam int unsigned ADDR_W    = 16;

    // bit positions the bank decoder depends on
    localparam int unsigned LANG_BIT  = 0;
    localparam int unsigned SYS_BIT   = 1;
    localparam int unsigned IO_BIT    = 2;
    localparam int unsigned MOTOR_BIT = 5;

    localparam logic [PORT_W-1:0] DIR_INIT  = 8'h2F;
    localparam logic [PORT_W-1:0] DATA_INIT = 8'h37;

    localparam logic [ADDR_W-1:0] DIR_ADDR  = 16'h0000;
    localparam logic [ADDR_W-1:0] DATA_ADDR = 16'h0001;

    typedef struct packed {
        logic lang_rom;
        logic sys_rom;
        logic io_vis;
        logic motor;
    } bank_t;

    // input-configured bits float high through the pull-ups
    function automatic logic [PORT_W-1:0] effective_bits(
        input logic [PORT_W-1:0] dir,
        input logic [PORT_W-1:0] dat
    );
        return (dir & dat) | ~dir;
    endfunction

    // per-bit merge for reads: latched value on outputs, pin on inputs
    function automatic logic [PORT_W-1:0] merge_read(
        input logic [PORT_W-1:0] dir,
        input logic [PORT_W-1:0] dat,
        input logic [PORT_W-1:0] pins
    );
        return (dir & dat) | (~dir & pins);
    endfunction

endpackage

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int unsigned            W     = PORT_W,
    parameter int unsigned            AW    = ADDR_W,
    parameter logic [AW-1:0]          A_DIR = DIR_ADDR,
    parameter logic [AW-1:0]          A_DAT = DATA_ADDR,
    parameter logic [W-1:0]           R_DIR = DIR_INIT,
    parameter logic [W-1:0]           R_DAT = DATA_INIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  data_q
);

    logic hit_dir, hit_dat;

    always_comb begin
        hit_dir = we && (addr == A_DIR);
        hit_dat = we && (addr == A_DAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= R_DIR;
            data_q <= R_DAT;
        end else begin
            if (hit_dir) dir_q  <= wdata;
            if (hit_dat) data_q <= wdata;
        end
    end

    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (dir_q == R_DIR) && (data_q == R_DAT));

    a_r2_dir_load: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_DIR) |=> dir_q == $past(wdata));

    a_r3_data_load: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_DAT) |=> data_q == $past(wdata));

    a_r5_hold_other: assert property (@(posedge clk) disable iff (rst)
        !(we && (addr == A_DIR || addr == A_DAT)) |=> $stable(dir_q) && $stable(data_q));

endmodule

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];

    // warm-up counter so the two-cycle look-back never reaches into reset
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    if (STAGES == 2) begin : g_chk
        a_r4_two_edge_delay: assert property (@(posedge clk) disable iff (rst || age < 2'd2)
            1'b1 |-> q == $past(d, 2));
    end

endmodule

// File: rtl/pport_bank.sv
module pport_bank
    import pport_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] dat,
    output bank_t        bank
);

    logic [W-1:0] eff;

    always_comb begin
        eff           = effective_bits(dir, dat);
        bank.lang_rom = eff[LANG_BIT] & eff[SYS_BIT];
        bank.sys_rom  = eff[SYS_BIT];
        bank.io_vis   = eff[IO_BIT];
        bank.motor    = dir[MOTOR_BIT] & dat[MOTOR_BIT];
    end

endmodule

// File: rtl/pport_top.sv
module pport_top
    import pport_pkg::*;
#(
    parameter int unsigned W  = PORT_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_we,
    input  logic [W-1:0]  cpu_wdata,
    output logic [W-1:0]  cpu_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic          lang_rom_en,
    output logic          sys_rom_en,
    output logic          io_visible,
    output logic          motor_on
);

    logic [W-1:0] dir_q, data_q, pins_s;
    bank_t        bank;

    pport_regs #(.W(W), .AW(AW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (cpu_addr),
        .we    (cpu_we),
        .wdata (cpu_wdata),
        .dir_q (dir_q),
        .data_q(data_q)
    );

    pport_sync #(.W(W), .STAGES(2)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pin_in),
        .q  (pins_s)
    );

    pport_bank #(.W(W)) u_bank (
        .dir (dir_q),
        .dat (data_q),
        .bank(bank)
    );

    always_comb begin
        if (cpu_addr == DIR_ADDR)       cpu_rdata = dir_q;
        else if (cpu_addr == DATA_ADDR) cpu_rdata = merge_read(dir_q, data_q, pins_s);
        else                            cpu_rdata = '0;
    end

    assign pin_out     = data_q;
    assign pin_oe      = dir_q;
    assign lang_rom_en = bank.lang_rom;
    assign sys_rom_en  = bank.sys_rom;
    assign io_visible  = bank.io_vis;
    assign motor_on    = bank.motor;

    a_r6_io_pullup: assert property (@(posedge clk) disable iff (rst)
        !pin_oe[IO_BIT] |-> io_visible);

    a_r7_lang_needs_sys: assert property (@(posedge clk) disable iff (rst)
        lang_rom_en |-> sys_rom_en);

    a_r10_motor_input_off: assert property (@(posedge clk) disable iff (rst)
        !pin_oe[MOTOR_BIT] |-> !motor_on);

    a_r5_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr > DATA_ADDR) |-> cpu_rdata == '0);

endmodule

// File: tb/pport_top_test.sv
module pport_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic        lang_rom_en, sys_rom_en, io_visible, motor_on;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pport_top uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .lang_rom_en(lang_rom_en),
        .sys_rom_en(sys_rom_en), .io_visible(io_visible), .motor_on(motor_on)
    );

    // {wdata to $0001, lang, sys, io, motor}; direction held at $2F, pins low
    localparam logic [11:0] VEC [8] = '{
        {8'h37, 4'b1111},   // R11 normal map
        {8'h34, 4'b0011},   // R11 RAM over ROMs, I/O kept
        {8'h36, 4'b0111},   // R7 R8 only bit1
        {8'h35, 4'b0011},   // R7 bit0 alone
        {8'h33, 4'b1101},   // R9 character ROM
        {8'h30, 4'b0001},   // R9
        {8'h17, 4'b1110},   // R10 motor off
        {8'h07, 4'b1110}    // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(posedge clk); #1;
        cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
        cpu_addr = a; #1;
        d = cpu_rdata;
    endtask

    initial begin
        logic [7:0] rd;
        @(posedge clk); @(posedge clk); #1;
        // R1 state while in reset
        check("R1 oe", pin_oe, 8'h2F);
        check("R1 out", pin_out, 8'h37);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1 map", {lang_rom_en, sys_rom_en, io_visible, motor_on}, 4'b1111);
        cpu_read(16'h0000, rd); check("R1 R2 dir read", rd, 8'h2F);
        cpu_read(16'h0001, rd); check("R1 R4 data read", rd, 8'h27);

        for (int i = 0; i < 8; i++) begin
            cpu_write(16'h0001, VEC[i][11:4]);
            check("R3 pin_out", pin_out, VEC[i][11:4]);
            check("R7 R8 R9 R10 map", {lang_rom_en, sys_rom_en, io_visible, motor_on}, VEC[i][3:0]);
            cpu_read(16'h0001, rd);
            check("R4 readback", rd, VEC[i][11:4] & 8'h2F);
        end

        // data now $07; make bits 0..2 outputs, then all inputs
        cpu_write(16'h0001, 8'h30);
        cpu_write(16'h0000, 8'h07);
        check("R2 oe", pin_oe, 8'h07);
        check("R9 R11 all low", {lang_rom_en, sys_rom_en, io_visible}, 3'b000);
        cpu_write(16'h0000, 8'h00);
        check("R6 pull-up map", {lang_rom_en, sys_rom_en, io_visible, motor_on}, 4'b1110);
        cpu_read(16'h0000, rd); check("R2 dir read", rd, 8'h00);

        // R4 synchroniser latency
        pin_in = 8'hA5;
        @(posedge clk); @(posedge clk); @(posedge clk); #1;
        cpu_read(16'h0001, rd); check("R4 pins settled", rd, 8'hA5);
        @(posedge clk); #1;
        pin_in = 8'h5A;
        @(posedge clk); #1;
        cpu_read(16'h0001, rd); check("R4 after one edge", rd, 8'hA5);
        @(posedge clk); #1;
        cpu_read(16'h0001, rd); check("R4 after two edges", rd, 8'h5A);

        // R4 mixed: upper nibble output ($30 latched), lower nibble pins
        cpu_write(16'h0000, 8'hF0);
        cpu_read(16'h0001, rd); check("R4 mixed", rd, 8'h3A);

        // R5 writes elsewhere ignored, reads elsewhere zero
        cpu_write(16'h0002, 8'hFF);
        cpu_write(16'h0100, 8'h00);
        cpu_write(16'hFFFF, 8'h55);
        check("R5 dir kept", pin_oe, 8'hF0);
        check("R5 data kept", pin_out, 8'h30);
        cpu_read(16'h0002, rd); check("R5 unmapped read", rd, 8'h00);
        cpu_read(16'h0101, rd); check("R5 unmapped read hi", rd, 8'h00);

        // R1 reset mid-run
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        check("R1 re-reset oe", pin_oe, 8'h2F);
        check("R1 re-reset out", pin_out, 8'h37);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule